// File: doc/BRIEF.md
# Boundary-Scan Instruction Register Path

This block is the instruction half of a boundary-scan test access port. A 6-bit serial stage sits between the test data input and the test data output. In the instruction-capture state it takes a fixed marker pattern in parallel. In the instruction-shift state it moves one bit per test clock toward the output. A separate 6-bit holding register feeds the instruction decoder. That holding register only moves when the controller passes through the instruction-update state or is reset, so a half-shifted opcode never reaches the decoder.

The port state machine is not part of the block. Its current state arrives as one strobe per state of interest: logic-reset, instruction capture, instruction shift, instruction update and data shift. These strobes change just after the rising test-clock edge, like a real controller's state.

The block acts on both clock edges:
- On the rising edge it captures or shifts the serial stage.
- On the falling edge it latches the instruction, retimes the serial output and drives the output-enable.

A two-way decode flags the identification opcode. Every other opcode, including all ones, selects the single-bit bypass path.

Top module: `tapir_path`

## Requirements
- R1: A rising test-clock edge that ends the instruction-capture state loads the serial stage with the constant 000001 (bit 0 set, bits 5..1 clear).
- R2: A rising edge that ends the instruction-shift state moves the serial stage one place toward bit 0, with the data input entering bit 5. On the falling edge inside each instruction-shift state, the serial output takes the current bit 0.
- R3: The serial output keeps its value on every falling edge outside the instruction-shift state.
- R4: On the falling edge inside the instruction-update state, the instruction register takes the full contents of the serial stage.
- R5: The instruction register changes only on a falling edge in the instruction-update state, in the logic-reset state, or while the active-low reset is low. Shifting, capturing and pausing leave it unchanged.
- R6: In any state other than capture or shift (pause, exit, update, data-side states), the serial stage holds its contents on the rising edge.
- R7: On a falling edge with the active-low reset low, or in the logic-reset state, the instruction register loads the reset opcode. The reset opcode is the identification opcode 000010, or all ones when no identification register is configured. Reset wins over a simultaneous update. The active-low reset also loads the serial stage with 000001 and clears the serial output.
- R8: The output-enable is set on the falling edge inside the instruction-shift or data-shift state and cleared on the falling edge inside any other state.
- R9: The identification select is high exactly when the instruction equals 000010. The bypass select is high for every other opcode, including 111111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low reset, sampled on test-clock edges |
| tdi | input | 1 | Serial test data input |
| st_tlr | input | 1 | Controller is in the logic-reset state |
| st_cap_ir | input | 1 | Controller is in the instruction-capture state |
| st_sh_ir | input | 1 | Controller is in the instruction-shift state |
| st_upd_ir | input | 1 | Controller is in the instruction-update state |
| st_sh_dr | input | 1 | Controller is in the data-shift state |
| tdo | output | 1 | Serial test data output, changes on the falling edge |
| tdo_oe | output | 1 | Drive enable for the serial output |
| instr | output | 6 | Current latched instruction |
| sel_bypass | output | 1 | Bypass path selected |
| sel_idcode | output | 1 | Identification register selected |

## Verification
The update latch and the reset load both act on the instruction register on the same falling edge. The bench shifts a non-reset opcode into the stage and then raises the update strobe together with the logic-reset strobe. In a second case it raises the update strobe while the active-low reset is low. In both cases the instruction must read the reset opcode, not the shifted value. Bench and checker also judge the rising-edge capture and the falling-edge serial output, which fall in the same clock period. The bench does this by comparing the serial output bit by bit against the captured marker.

// File: rtl/tapir_pkg.sv
// Package: shared defaults and the controller-state bundle for the
// instruction register path. Assumes a 6-bit instruction by default.
package tapir_pkg;

    localparam int DEF_IR_W = 6;

    // Controller states that this block reacts to, one strobe each.
    typedef struct packed {
        logic tlr;
        logic cap_ir;
        logic sh_ir;
        logic upd_ir;
        logic sh_dr;
    } tap_state_t;

endpackage

// File: rtl/tapir_shift.sv
// Serial capture/shift stage. Acts on the rising test-clock edge.
// Assumes capture and shift strobes are never high together.
module tapir_shift #(
    parameter int                IR_W    = 6,
    parameter logic [IR_W-1:0]   CAP_VAL = {{(IR_W-1){1'b0}}, 1'b1}
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            capture,
    input  logic            shift,
    input  logic            tdi,
    output logic [IR_W-1:0] sr_q
);

    // Capture the marker, shift toward bit 0, or hold.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            sr_q <= CAP_VAL;
        end else if (capture) begin
            sr_q <= CAP_VAL;
        end else if (shift) begin
            sr_q <= {tdi, sr_q[IR_W-1:1]};
        end
    end

endmodule

// File: rtl/tapir_latch.sv
// Instruction holding register. Acts on the falling test-clock edge.
// Reset (pin or logic-reset state) has priority over update.
module tapir_latch #(
    parameter int              IR_W   = 6,
    parameter logic [IR_W-1:0] RST_OP = {IR_W{1'b1}}
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tlr,
    input  logic            update,
    input  logic [IR_W-1:0] sr_q,
    output logic [IR_W-1:0] instr_q
);

    // Load the reset opcode, copy the stage on update, else hold.
    always_ff @(negedge tck) begin
        if (!trst_n || tlr) begin
            instr_q <= RST_OP;
        end else if (update) begin
            instr_q <= sr_q;
        end
    end

endmodule

// File: rtl/tapir_serial_out.sv
// Falling-edge retiming of the serial output and its drive enable.
// Assumes the stage bit 0 is stable across the falling edge.
module tapir_serial_out (
    input  logic tck,
    input  logic trst_n,
    input  logic shift_ir,
    input  logic shift_dr,
    input  logic sr_lsb,
    output logic tdo,
    output logic tdo_oe
);

    // Present stage bit 0 during instruction shift, hold otherwise.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo <= 1'b0;
        end else if (shift_ir) begin
            tdo <= sr_lsb;
        end
    end

    // Enable the driver only in the two shift states.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= shift_ir | shift_dr;
        end
    end

endmodule

// File: rtl/tapir_decode.sv
// Minimal decode: identification opcode versus bypass for all others.
// With HAS_ID = 0 every opcode selects bypass.
module tapir_decode #(
    parameter int              IR_W   = 6,
    parameter bit              HAS_ID = 1'b1,
    parameter logic [IR_W-1:0] ID_OP  = 6'b000010
) (
    input  logic [IR_W-1:0] instr,
    output logic            sel_bypass,
    output logic            sel_idcode
);

    generate
        if (HAS_ID) begin : g_with_id
            // Compare against the identification opcode.
            always_comb begin
                sel_idcode = (instr == ID_OP);
                sel_bypass = !sel_idcode;
            end
        end else begin : g_no_id
            // No identification register: bypass always selected.
            always_comb begin
                sel_idcode = 1'b0;
                sel_bypass = 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/tapir_path.sv
// Top of the instruction register path. Rising edge: capture/shift.
// Falling edge: instruction latch, serial output, output enable.
// Assumes the state strobes change just after the rising edge.
module tapir_path #(
    parameter int              IR_W    = tapir_pkg::DEF_IR_W,
    parameter bit              HAS_ID  = 1'b1,
    parameter logic [IR_W-1:0] ID_OP   = 6'b000010,
    parameter logic [IR_W-1:0] CAP_VAL = {{(IR_W-1){1'b0}}, 1'b1}
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            st_tlr,
    input  logic            st_cap_ir,
    input  logic            st_sh_ir,
    input  logic            st_upd_ir,
    input  logic            st_sh_dr,
    output logic            tdo,
    output logic            tdo_oe,
    output logic [IR_W-1:0] instr,
    output logic            sel_bypass,
    output logic            sel_idcode
);

    localparam logic [IR_W-1:0] RST_OP = HAS_ID ? ID_OP : {IR_W{1'b1}};

    tapir_pkg::tap_state_t st;
    logic [IR_W-1:0]       sr_q;

    // Bundle the incoming state strobes.
    always_comb begin
        st.tlr    = st_tlr;
        st.cap_ir = st_cap_ir;
        st.sh_ir  = st_sh_ir;
        st.upd_ir = st_upd_ir;
        st.sh_dr  = st_sh_dr;
    end

    tapir_shift #(.IR_W(IR_W), .CAP_VAL(CAP_VAL)) u_shift (
        .tck     (tck),
        .trst_n  (trst_n),
        .capture (st.cap_ir),
        .shift   (st.sh_ir),
        .tdi     (tdi),
        .sr_q    (sr_q)
    );

    tapir_latch #(.IR_W(IR_W), .RST_OP(RST_OP)) u_latch (
        .tck     (tck),
        .trst_n  (trst_n),
        .tlr     (st.tlr),
        .update  (st.upd_ir),
        .sr_q    (sr_q),
        .instr_q (instr)
    );

    tapir_serial_out u_sout (
        .tck      (tck),
        .trst_n   (trst_n),
        .shift_ir (st.sh_ir),
        .shift_dr (st.sh_dr),
        .sr_lsb   (sr_q[0]),
        .tdo      (tdo),
        .tdo_oe   (tdo_oe)
    );

    tapir_decode #(.IR_W(IR_W), .HAS_ID(HAS_ID), .ID_OP(ID_OP)) u_dec (
        .instr      (instr),
        .sel_bypass (sel_bypass),
        .sel_idcode (sel_idcode)
    );

endmodule

// File: rtl/tapir_path_chk.sv
// Checker for tapir_path: edge-by-edge rules on stage, latch and output.
module tapir_path_chk #(
    parameter int              IR_W    = 6,
    parameter logic [IR_W-1:0] RST_OP  = 6'b000010,
    parameter logic [IR_W-1:0] CAP_VAL = 6'b000001,
    parameter logic [IR_W-1:0] ID_OP   = 6'b000010,
    parameter bit              HAS_ID  = 1'b1
) (
    input logic            tck,
    input logic            trst_n,
    input logic            tdi,
    input logic            st_tlr,
    input logic            st_cap_ir,
    input logic            st_sh_ir,
    input logic            st_upd_ir,
    input logic            st_sh_dr,
    input logic            tdo,
    input logic            tdo_oe,
    input logic [IR_W-1:0] instr,
    input logic [IR_W-1:0] sr_q,
    input logic            sel_bypass,
    input logic            sel_idcode
);

    p_capture_r1: assert property (@(posedge tck) disable iff (!trst_n)
        st_cap_ir |=> sr_q == CAP_VAL);

    p_shift_r2: assert property (@(posedge tck) disable iff (!trst_n)
        st_sh_ir |=> sr_q == {$past(tdi), $past(sr_q[IR_W-1:1])});

    p_tdo_hold_r3: assert property (@(negedge tck) disable iff (!trst_n)
        !st_sh_ir |=> $stable(tdo));

    p_update_r4: assert property (@(negedge tck) disable iff (!trst_n)
        (st_upd_ir && !st_tlr) |=> instr == $past(sr_q));

    p_instr_only_update_r5: assert property (@(negedge tck) disable iff (!trst_n)
        (!st_upd_ir && !st_tlr) |=> $stable(instr));

    p_stage_hold_r6: assert property (@(posedge tck) disable iff (!trst_n)
        (!st_cap_ir && !st_sh_ir) |=> $stable(sr_q));

    p_reset_op_r7: assert property (@(negedge tck) disable iff (!trst_n)
        st_tlr |=> instr == RST_OP);

    p_oe_on_r8: assert property (@(negedge tck) disable iff (!trst_n)
        (st_sh_ir || st_sh_dr) |=> tdo_oe);

    p_oe_off_r8: assert property (@(negedge tck) disable iff (!trst_n)
        (!st_sh_ir && !st_sh_dr) |=> !tdo_oe);

    p_decode_r9: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot({sel_bypass, sel_idcode}) &&
        (sel_idcode == (HAS_ID && instr == ID_OP)));

endmodule

bind tapir_path tapir_path_chk #(
    .IR_W(IR_W), .RST_OP(RST_OP), .CAP_VAL(CAP_VAL), .ID_OP(ID_OP), .HAS_ID(HAS_ID)
) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .tdi        (tdi),
    .st_tlr     (st_tlr),
    .st_cap_ir  (st_cap_ir),
    .st_sh_ir   (st_sh_ir),
    .st_upd_ir  (st_upd_ir),
    .st_sh_dr   (st_sh_dr),
    .tdo        (tdo),
    .tdo_oe     (tdo_oe),
    .instr      (instr),
    .sr_q       (sr_q),
    .sel_bypass (sel_bypass),
    .sel_idcode (sel_idcode)
);

// File: tb/tapir_path_bench.sv
// Bench: loads every 6-bit opcode, checks serial path, latch timing,
// reset priority and the output enable against arithmetic expectations.
module tapir_path_bench;

    localparam logic [5:0] CAPV = 6'b000001;
    localparam logic [5:0] IDOP = 6'b000010;

    // State codes for step(): {sh_dr, upd, sh_ir, cap, tlr}
    localparam logic [4:0] S_IDLE = 5'b00000;
    localparam logic [4:0] S_TLR  = 5'b00001;
    localparam logic [4:0] S_CAP  = 5'b00010;
    localparam logic [4:0] S_SH   = 5'b00100;
    localparam logic [4:0] S_UPD  = 5'b01000;
    localparam logic [4:0] S_SHDR = 5'b10000;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tdi = 1'b0;
    logic [4:0] st = 5'b0;
    logic       tdo, tdo_oe, sel_bypass, sel_idcode;
    logic [5:0] instr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 tck = ~tck;

    tapir_path u_tapir_path (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .st_tlr     (st[0]),
        .st_cap_ir  (st[1]),
        .st_sh_ir   (st[2]),
        .st_upd_ir  (st[3]),
        .st_sh_dr   (st[4]),
        .tdo        (tdo),
        .tdo_oe     (tdo_oe),
        .instr      (instr),
        .sel_bypass (sel_bypass),
        .sel_idcode (sel_idcode)
    );

    task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
        end
    endtask

    // One controller state: drive after rising edge, sample after falling edge.
    task automatic step(input logic [4:0] s, input logic d);
        @(posedge tck);
        #1;
        st  = s;
        tdi = d;
        @(negedge tck);
        #1;
    endtask

    task automatic chk_decode(input logic [5:0] op);
        chk("R9 idcode sel", {5'b0, sel_idcode}, {5'b0, op == IDOP});
        chk("R9 bypass sel", {5'b0, sel_bypass}, {5'b0, op != IDOP});
    endtask

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [5:0] prev;
        logic [5:0] junk;
        logic       last_tdo;

        // Reset state (R7, R8)
        step(S_IDLE, 1'b0);
        step(S_IDLE, 1'b0);
        chk("R7 reset opcode", instr, IDOP);
        chk("R7 reset tdo", {5'b0, tdo}, 6'b0);
        chk("R8 reset oe", {5'b0, tdo_oe}, 6'b0);
        chk_decode(IDOP);
        @(posedge tck);
        #1;
        trst_n = 1'b1;
        prev = IDOP;

        // Sweep every opcode through capture, 12 shifts, exit, update
        for (int op = 0; op < 64; op++) begin
            junk = 6'(op) ^ 6'h2A;
            step(S_CAP, 1'b0);
            chk("R5 capture keeps instr", instr, prev);
            for (int i = 0; i < 12; i++) begin
                logic d;
                logic e;
                d = (i < 6) ? junk[i] : 1'(op >> (i - 6));
                e = (i < 6) ? CAPV[i] : junk[i-6];
                step(S_SH, d);
                chk((i < 6) ? "R1 captured bit on tdo" : "R2 shifted bit on tdo",
                    {5'b0, tdo}, {5'b0, e});
                chk("R8 oe in shift", {5'b0, tdo_oe}, 6'b1);
                chk("R5 shift keeps instr", instr, prev);
            end
            last_tdo = tdo;
            step(S_IDLE, 1'b1);
            chk("R3 tdo held", {5'b0, tdo}, {5'b0, last_tdo});
            chk("R8 oe off", {5'b0, tdo_oe}, 6'b0);
            chk("R5 exit keeps instr", instr, prev);
            step(S_UPD, 1'b0);
            chk("R4 update loads", instr, 6'(op));
            chk_decode(6'(op));
            prev = 6'(op);
        end

        // Pause mid-shift: stage must hold (R6), tdo held (R3)
        step(S_CAP, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step(S_SH, 1'b0);
            chk("R1 captured bit", {5'b0, tdo}, {5'b0, CAPV[i]});
        end
        step(S_IDLE, 1'b1);
        step(S_UPD, 1'b1);
        chk("R4 partial update", instr, 6'b000000);
        step(S_SHDR, 1'b1);
        chk("R8 oe in data shift", {5'b0, tdo_oe}, 6'b1);
        chk("R3 tdo held in data shift", {5'b0, tdo}, {5'b0, CAPV[2]});
        chk("R5 data shift keeps instr", instr, 6'b000000);
        for (int i = 3; i < 6; i++) begin
            step(S_SH, 1'b1);
            chk("R6 held stage resumes", {5'b0, tdo}, {5'b0, CAPV[i]});
        end
        step(S_IDLE, 1'b0);

        // Update with logic-reset in the same state: reset wins (R7)
        step(S_CAP, 1'b0);
        for (int i = 0; i < 6; i++) step(S_SH, 1'b1);
        step(S_IDLE, 1'b0);
        step(S_UPD | S_TLR, 1'b0);
        chk("R7 reset beats update", instr, IDOP);
        chk_decode(IDOP);
        step(S_UPD, 1'b0);
        chk("R4 stage kept after tlr", instr, 6'b111111);
        chk_decode(6'b111111);

        // Logic-reset alone, then pin reset during update (R7)
        step(S_TLR, 1'b0);
        chk("R7 tlr loads id", instr, IDOP);
        step(S_UPD, 1'b0);
        chk("R4 reupdate", instr, 6'b111111);
        @(posedge tck);
        #1;
        trst_n = 1'b0;
        step(S_UPD, 1'b0);
        chk("R7 pin reset beats update", instr, IDOP);
        chk("R7 pin reset tdo", {5'b0, tdo}, 6'b0);
        @(posedge tck);
        #1;
        trst_n = 1'b1;
        step(S_SH, 1'b0);
        chk("R7 pin reset reloads stage", {5'b0, tdo}, {5'b0, CAPV[0]});
        step(S_IDLE, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule